// File: doc/BRIEF.md
# Floating-Point Control and Condition-Code Register

This block holds the 32-bit control/status word of a floating-point unit. An issue or execute stage reads and writes it in four ways. A full-word port loads or returns the whole word. A condition-code port writes or reads one of eight condition bits, chosen by a 3-bit index. An exception port raises the sticky flag and cause bits for one exception type. An issue strobe marks each instruction issue.

The eight condition codes do not sit in one contiguous run of bits. Code 0 is at bit 23. Codes 1 to 7 are at bits 25 to 31. Bit 24 lies between them and is the flush-to-zero control, not a condition code.

Each issue strobe moves a two-stage pipeline of condition code 0. One stage holds the value seen by the current instruction and the other holds the value seen by the one before it. The rounding mode is decoded from the two lowest bits and driven out for the arithmetic datapath. All ports are plain control and status pins. No port has a valid/ready handshake, and nothing applies back-pressure: every strobe takes effect at the next rising clock edge.

Top module: `fcsr_unit`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, the register word, `cc0_cur` and `cc0_prev` are all zero.
- R2: When `wr_en` is high, `rd_data` shows `wr_data` after the next rising edge, combined with any exception or condition-code update from the same cycle.
- R3: A condition-code write with index 0 changes only bit 23. A write with index n from 1 to 7 changes only bit 24+n. The addressed bit takes `cc_wr_val`.
- R4: Condition-code writes never change bit 24. The `flush_zero` output always equals bit 24.
- R5: `cc_rd_val` is the single bit at the position that R3 assigns to index `cc_rd_idx`, taken from the current register word. Its value is exactly 0 or 1.
- R6: `rnd_mode` equals bits 1:0 of the word: 0 is round to nearest, 1 is toward zero, 2 is toward +infinity, 3 is toward -infinity.
- R7: An exception report of type b (0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid, 5 unimplemented) sets cause bit 12+b. For b below 5 it also sets flag bit 2+b. Bits already set stay set, and all other bits are unchanged. Enable bits 7+b are reached only through the full-word port.
- R8: An exception report with type 6 or 7 leaves the register word unchanged.
- R9: On an issue strobe, `cc0_prev` takes the old `cc0_cur`, and `cc0_cur` takes bit 23 as it stood before that edge. Without a strobe, both hold their values.
- R10: When a full-word write and a condition-code write occur in the same cycle, the addressed condition bit takes `cc_wr_val`. Every other bit takes `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Full-word write value |
| cc_wr_en | input | 1 | Condition-code write strobe |
| cc_wr_idx | input | 3 | Condition-code write index |
| cc_wr_val | input | 1 | Condition-code write value |
| cc_rd_idx | input | 3 | Condition-code read index |
| cc_rd_val | output | 1 | Addressed condition-code bit |
| exc_valid | input | 1 | Exception report strobe |
| exc_type | input | 3 | Exception type code |
| issue | input | 1 | Instruction issue strobe |
| rd_data | output | 32 | Current register word |
| cc0_cur | output | 1 | Condition code 0 seen by the current instruction |
| cc0_prev | output | 1 | Condition code 0 seen by the previous instruction |
| rnd_mode | output | 2 | Decoded rounding mode |
| flush_zero | output | 1 | Flush-to-zero control bit |

## Verification
On every cycle, the assertions check the following: the reset values; the movement of the issue pipeline and its holding between strobes; that condition-code writes land on the mapped bit and leave bit 24 alone; that cause bits are raised; and that out-of-range exception types have no effect. Other behaviour can be shown only by the bench's scenarios, which compare against an independent model of the whole word. This covers the exact positions of the flag bits, the absence of a flag for the unimplemented type, priority when writes collide, the rounding-mode decode, and the fact that no unaddressed bit moves during long random mixes of all four ports.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int CSR_W      = 32;
  localparam int POS_W      = $clog2(CSR_W);
  localparam int NUM_CC     = 8;
  localparam int CC_IDX_W   = $clog2(NUM_CC);
  localparam int CC0_POS    = 23;
  localparam int CC_BASE    = 24;
  localparam int FTZ_POS    = 24;
  localparam int EXC_W      = 3;
  localparam int NUM_FLAG   = 5;
  localparam int NUM_CAUSE  = 6;
  localparam int FLAG_BASE  = 2;
  localparam int ENA_BASE   = 7;
  localparam int CAUSE_BASE = 12;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POS_INF = 2'd2,
    RND_NEG_INF = 2'd3
  } rnd_mode_e;

  // Bit position of a condition code; the index space skips the flush bit.
  function automatic logic [POS_W-1:0] cc_pos(input logic [CC_IDX_W-1:0] idx);
    return (idx == '0) ? POS_W'(CC0_POS) : POS_W'(CC_BASE) + POS_W'(idx);
  endfunction
endpackage

// File: rtl/fcsr_cc_port.sv
module fcsr_cc_port
  import fcsr_pkg::*;
(
  input  logic [CSR_W-1:0]    csr_q,
  input  logic [CC_IDX_W-1:0] wr_idx,
  input  logic [CC_IDX_W-1:0] rd_idx,
  output logic [CSR_W-1:0]    wr_mask,
  output logic                rd_val
);
  logic [NUM_CC-1:0] cc_vec;
  logic [NUM_CC-1:0] wr_sel;

  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    localparam int P = (g == 0) ? CC0_POS : CC_BASE + g;
    assign cc_vec[g] = csr_q[P];
    assign wr_sel[g] = (wr_idx == CC_IDX_W'(g));
  end

  always_comb begin
    wr_mask = '0;
    for (int g = 0; g < NUM_CC; g++) begin
      if (wr_sel[g]) wr_mask[(g == 0) ? CC0_POS : CC_BASE + g] = 1'b1;
    end
  end

  assign rd_val = cc_vec[rd_idx];
endmodule

// File: rtl/fcsr_exc_decode.sv
module fcsr_exc_decode
  import fcsr_pkg::*;
(
  input  logic             exc_valid,
  input  logic [EXC_W-1:0] exc_type,
  output logic [CSR_W-1:0] set_mask
);
  logic [NUM_CAUSE-1:0] hit;

  for (genvar b = 0; b < NUM_CAUSE; b++) begin : g_hit
    assign hit[b] = exc_valid && (exc_type == EXC_W'(b));
  end

  // Types at or above NUM_CAUSE match no entry and give an all-zero mask.
  always_comb begin
    set_mask = '0;
    for (int b = 0; b < NUM_CAUSE; b++) begin
      if (hit[b]) begin
        set_mask[CAUSE_BASE + b] = 1'b1;
        if (b < NUM_FLAG) set_mask[FLAG_BASE + b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcsr_issue_hist.sv
module fcsr_issue_hist (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic cc0_now,
  output logic cur_q,
  output logic prev_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (issue) begin
      prev_q <= cur_q;
      cur_q  <= cc0_now;
    end
  end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CSR_W-1:0]    wr_data,
  input  logic                cc_wr_en,
  input  logic [CC_IDX_W-1:0] cc_wr_idx,
  input  logic                cc_wr_val,
  input  logic [CC_IDX_W-1:0] cc_rd_idx,
  output logic                cc_rd_val,
  input  logic                exc_valid,
  input  logic [EXC_W-1:0]    exc_type,
  input  logic                issue,
  output logic [CSR_W-1:0]    rd_data,
  output logic                cc0_cur,
  output logic                cc0_prev,
  output logic [1:0]          rnd_mode,
  output logic                flush_zero
);
  logic [CSR_W-1:0] csr_q, csr_d, cc_mask, exc_mask;
  rnd_mode_e        rm;

  fcsr_cc_port u_cc (
    .csr_q   (csr_q),
    .wr_idx  (cc_wr_idx),
    .rd_idx  (cc_rd_idx),
    .wr_mask (cc_mask),
    .rd_val  (cc_rd_val)
  );

  fcsr_exc_decode u_exc (
    .exc_valid (exc_valid),
    .exc_type  (exc_type),
    .set_mask  (exc_mask)
  );

  fcsr_issue_hist u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .cc0_now (csr_q[CC0_POS]),
    .cur_q   (cc0_cur),
    .prev_q  (cc0_prev)
  );

  // Priority: word write, then sticky exception bits, then the condition bit.
  always_comb begin
    csr_d = wr_en ? wr_data : csr_q;
    csr_d = csr_d | exc_mask;
    if (cc_wr_en) csr_d = (csr_d & ~cc_mask) | ({CSR_W{cc_wr_val}} & cc_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;
  end

  assign rm         = rnd_mode_e'(csr_q[1:0]);
  assign rnd_mode   = rm;
  assign flush_zero = csr_q[FTZ_POS];
  assign rd_data    = csr_q;
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk
  import fcsr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                cc_wr_en,
  input logic [CC_IDX_W-1:0] cc_wr_idx,
  input logic                cc_wr_val,
  input logic [CC_IDX_W-1:0] cc_rd_idx,
  input logic                cc_rd_val,
  input logic                exc_valid,
  input logic [EXC_W-1:0]    exc_type,
  input logic                issue,
  input logic [CSR_W-1:0]    rd_data,
  input logic                cc0_cur,
  input logic                cc0_prev
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_data == '0 && !cc0_cur && !cc0_prev));

  assert_cc_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cc_wr_en |=> rd_data[cc_pos($past(cc_wr_idx))] == $past(cc_wr_val));

  assert_flush_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_wr_en && !wr_en) |=> rd_data[FTZ_POS] == $past(rd_data[FTZ_POS]));

  assert_cc_read_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_rd_val == rd_data[cc_pos(cc_rd_idx)]);

  assert_cause_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_type < EXC_W'(NUM_CAUSE) && !wr_en)
      |=> rd_data[POS_W'(CAUSE_BASE) + POS_W'($past(exc_type))]);

  assert_bad_type_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_type >= EXC_W'(NUM_CAUSE) && !wr_en && !cc_wr_en) |=> $stable(rd_data));

  assert_issue_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (cc0_prev == $past(cc0_cur) && cc0_cur == $past(rd_data[CC0_POS])));

  assert_issue_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(cc0_cur) && $stable(cc0_prev)));
endmodule

bind fcsr_unit fcsr_unit_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .cc_wr_en  (cc_wr_en),
  .cc_wr_idx (cc_wr_idx),
  .cc_wr_val (cc_wr_val),
  .cc_rd_idx (cc_rd_idx),
  .cc_rd_val (cc_rd_val),
  .exc_valid (exc_valid),
  .exc_type  (exc_type),
  .issue     (issue),
  .rd_data   (rd_data),
  .cc0_cur   (cc0_cur),
  .cc0_prev  (cc0_prev)
);

// File: tb/fcsr_unit_tb_top.sv
module fcsr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, cc_wr_en = 0, cc_wr_val = 0, exc_valid = 0, issue = 0;
  logic [31:0] wr_data = '0;
  logic [2:0]  cc_wr_idx = '0, cc_rd_idx = '0, exc_type = '0;
  logic        cc_rd_val, cc0_cur, cc0_prev, flush_zero;
  logic [31:0] rd_data;
  logic [1:0]  rnd_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_csr = '0;
  logic        m_cur = 0, m_prev = 0;

  always #5 clk = ~clk;

  fcsr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cc_wr_en(cc_wr_en), .cc_wr_idx(cc_wr_idx), .cc_wr_val(cc_wr_val),
    .cc_rd_idx(cc_rd_idx), .cc_rd_val(cc_rd_val),
    .exc_valid(exc_valid), .exc_type(exc_type), .issue(issue),
    .rd_data(rd_data), .cc0_cur(cc0_cur), .cc0_prev(cc0_prev),
    .rnd_mode(rnd_mode), .flush_zero(flush_zero)
  );

  // Condition-code bit positions as the requirements state them (R3).
  function automatic int bpos(input logic [2:0] i);
    return (i == 0) ? 23 : 24 + int'(i);
  endfunction

  function automatic logic [31:0] exc_bits(input logic v, input logic [2:0] t);
    logic [31:0] m = '0;
    if (v && t < 6) begin
      m[12 + int'(t)] = 1'b1;
      if (t < 5) m[2 + int'(t)] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] next_word(input logic [31:0] w);
    logic [31:0] n = wr_en ? wr_data : w;
    n |= exc_bits(exc_valid, exc_type);
    if (cc_wr_en) n[bpos(cc_wr_idx)] = cc_wr_val;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    chk(req, rd_data, m_csr);
    chk("R9 cur", {31'd0, cc0_cur}, {31'd0, m_cur});
    chk("R9 prev", {31'd0, cc0_prev}, {31'd0, m_prev});
    chk("R6 rounding", {30'd0, rnd_mode}, {30'd0, m_csr[1:0]});
    chk("R4 flush", {31'd0, flush_zero}, {31'd0, m_csr[24]});
  endtask

  // Drive at the falling edge, step the model at the rising edge, check after.
  task automatic step(input bit we, input logic [31:0] wd, input bit ce, input logic [2:0] ci,
                      input bit cv, input logic [2:0] ri, input bit ev, input logic [2:0] et,
                      input bit is, input string req);
    logic [31:0] nw;
    wr_en = we; wr_data = wd; cc_wr_en = ce; cc_wr_idx = ci; cc_wr_val = cv;
    cc_rd_idx = ri; exc_valid = ev; exc_type = et; issue = is;
    #1;
    chk("R5 cc read", {31'd0, cc_rd_val}, {31'd0, m_csr[bpos(ri)]});
    nw = next_word(m_csr);
    @(posedge clk);
    if (is) begin m_prev = m_cur; m_cur = m_csr[23]; end
    m_csr = nw;
    @(negedge clk);
    check_outs(req);
  endtask

  task automatic idle(input string req);
    step(0, '0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired before the run finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (2) @(negedge clk);
    check_outs("R1 in reset");
    rst_n = 1'b1;
    idle("R1 after release");

    // R2 and R6: full-word writes with every rounding mode
    for (int r = 0; r < 4; r++) step(1, 32'h5A00_F080 | r, 0, 0, 0, 0, 0, 0, 0, "R2 word write");
    step(1, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, "R2 clear");

    // R3 and R5: set then clear each condition code on a zero word
    for (int i = 0; i < 8; i++) begin
      step(0, '0, 1, 3'(i), 1, 3'(i), 0, 0, 0, "R3 set cc");
      chk("R3 only mapped bit", rd_data, 32'd1 << bpos(3'(i)));
      step(0, '0, 1, 3'(i), 0, 3'(i), 0, 0, 0, "R3 clear cc");
    end

    // R4: flush bit survives writes to all condition codes
    step(1, 32'h0100_0000, 0, 0, 0, 0, 0, 0, 0, "R2 set flush");
    for (int i = 0; i < 8; i++) step(0, '0, 1, 3'(i), 1, 3'(i), 0, 0, 0, "R4 cc set");
    chk("R4 all cc with flush", rd_data, 32'hFF80_0000);
    for (int i = 0; i < 8; i++) step(0, '0, 1, 3'(i), 0, 3'(i), 0, 0, 0, "R4 cc clear");
    chk("R4 flush kept", rd_data, 32'h0100_0000);

    // R7 and R8: every exception type on a zero word
    for (int t = 0; t < 8; t++) begin
      step(1, '0, 0, 0, 0, 0, 0, 0, 0, "R2 clear");
      step(0, '0, 0, 0, 0, 0, 1, 3'(t), 0, (t < 6) ? "R7 exception" : "R8 bad type");
    end
    step(0, '0, 0, 0, 0, 0, 1, 3'd0, 0, "R7 sticky");
    step(0, '0, 0, 0, 0, 0, 1, 3'd7, 0, "R8 bad type keeps word");

    // R9: issue pipeline of condition code 0
    step(0, '0, 1, 0, 1, 0, 0, 0, 1, "R9 issue");
    step(0, '0, 1, 0, 0, 0, 0, 0, 1, "R9 issue");
    step(0, '0, 0, 0, 0, 0, 0, 0, 1, "R9 issue");
    idle("R9 hold");
    step(0, '0, 0, 0, 0, 0, 0, 0, 1, "R9 issue");

    // R10: colliding word write and condition-code write
    step(1, 32'hFFFF_FFFF, 1, 3'd5, 0, 3'd5, 0, 0, 0, "R10 collide clear");
    step(1, 32'h0000_0000, 1, 3'd0, 1, 3'd0, 0, 0, 0, "R10 collide set");

    // Random mix of all ports
    for (int k = 0; k < 2000; k++) begin
      step(($urandom % 10) == 0, $urandom, ($urandom % 3) == 0, 3'($urandom),
           1'($urandom), 3'($urandom), ($urandom % 3) == 0, 3'($urandom),
           ($urandom % 2) == 0, "R2 random word");
      if (($urandom % 50) == 0) step(1, '0, 0, 0, 0, 0, 0, 0, 0, "R2 random clear");
    end

    done = 1;
    finish_run();
  end
endmodule